// File: doc/BRIEF.md
# Sync word detector with error tolerance

This block watches a stream of recovered receive bits and reports when the most recent bits form a programmed synchronisation word. It takes one bit on each cycle in which the bit-clock enable is high and keeps a sliding history of those bits. It compares the newest window against the programmed word. The window length can be 8, 16, 24 or 32 bits, and the comparison forgives up to three bit errors. When the number of mismatching bits is within the tolerance, it raises a single-cycle detection pulse. The packet or buffered data path uses that pulse to start taking payload.

The matcher is a three-state controller. In ST_IDLE hunting is disabled, and the history fill count is held at zero. In ST_HUNT bits are shifted in and compared. ST_HOLD is entered after a detection: bits are ignored there, so payload cannot cause a second match. The transitions are named as follows:
- IDLE→HUNT ("arm") when the enable goes high.
- HUNT→HOLD ("lock") on a match.
- HOLD→HUNT ("re-arm") on a restart pulse.
- HUNT→HUNT ("restart") when restart is seen while hunting; it empties the window.
- any→IDLE ("disable") when the enable goes low.

The programmed word arrives as four bytes packed into one bus. The first byte sits in the top eight bits, and the fourth byte in the bottom eight bits.

Top module: `sync_hunter`

## Requirements
- R1: After reset `found` is low. While `hunt_en` is low, no bit pattern produces a detection.
- R2: `size_sel` selects the window length: 00 = 8 bits, 01 = 16, 10 = 24, 11 = 32.
  - Byte 1 (`word_bytes[31:24]`) is always used.
  - Byte 2 (`[23:16]`) is used only when the size is not 00.
  - Byte 3 (`[15:8]`) is used only for sizes 10 and 11.
  - Byte 4 (`[7:0]`) is used only for size 11.
  - Unused bytes have no effect.
- R3: The first received bit of the window is compared with bit 7 of byte 1, and the following bits run MSB first through the used bytes in order. A bit-reversed pattern does not match.
- R4: `tol_sel` gives the number of mismatching bits accepted: 00 = 0, 01 = 1, 10 = 2, 11 = 3. A window with more mismatches than that is rejected.
- R5: `found` is high for exactly one clock. It rises in the cycle right after the clock edge that takes the bit completing a matching window.
- R6: No detection is made until at least as many bits as the window length have been taken since the matcher was last armed.
- R7: After a detection, further bits produce no detection until `restart` is pulsed. Restart also empties the window, and restart has priority over a bit presented in the same cycle.
- R8: Dropping `hunt_en` returns the matcher to idle and empties the window. A bit presented during that cycle is discarded. Raising `hunt_en` again re-arms after one clock.
- R9: Bits are taken only on cycles where `bit_en` is high. The value of `bit_in` on other cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hunt_en | input | 1 | Enables word recognition |
| restart | input | 1 | Re-arms the matcher and empties the window |
| bit_en | input | 1 | Bit-clock enable; `bit_in` is taken on this cycle |
| bit_in | input | 1 | Recovered receive bit |
| size_sel | input | 2 | Window length code |
| tol_sel | input | 2 | Accepted mismatch count |
| word_bytes | input | 32 | Sync word, byte 1 in the top bits |
| found | output | 1 | One-cycle detection pulse |

## Verification
The only result is `found`. It is due in the cycle that follows the rising edge which samples the bit completing the window, so it is one register away from the input. The bench drives every input on the falling edge. For each driven cycle, whether or not a bit is presented, it pushes one expected value of `found` into a scoreboard queue. The monitor pops that entry after the next rising edge and compares it at the following falling edge. As a result every cycle of the run is checked, including the gap, restart and disable cycles, where the pulse must stay low.

// File: rtl/sdet_pkg.sv
package sdet_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_HOLD = 2'd2
    } hunt_state_t;
endpackage

// File: rtl/sd_history.sv
module sd_history #(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic              bit_in,
    output logic [WORD_W-1:0] cand,
    output logic [CNT_W-1:0]  fill_cand
);
    localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(WORD_W);

    logic [WORD_W-2:0] hist;
    logic [CNT_W-1:0]  fill;

    // Window as it would look once the current bit is taken.
    assign cand      = {hist, bit_in};
    assign fill_cand = (fill == FILL_MAX) ? fill : fill + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
            fill <= '0;
        end else if (clear) begin
            hist <= '0;
            fill <= '0;
        end else if (take) begin
            hist <= cand[WORD_W-2:0];
            fill <= fill_cand;
        end
    end

    AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_MAX); // R6

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fill == '0)); // R7
endmodule

// File: rtl/sd_compare.sv
module sd_compare #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4,
    parameter int SIZE_W    = 2,
    parameter int TOL_W     = 2,
    parameter int CNT_W     = 6
) (
    input  logic [BYTE_W*NUM_BYTES-1:0] cand,
    input  logic [CNT_W-1:0]            fill_cand,
    input  logic [BYTE_W*NUM_BYTES-1:0] word,
    input  logic [SIZE_W-1:0]           size_sel,
    input  logic [TOL_W-1:0]            tol_sel,
    output logic                        hit
);
    localparam int WORD_W = BYTE_W * NUM_BYTES;

    logic [CNT_W-1:0]  len_bits;
    logic [WORD_W-1:0] ref_word;
    logic [WORD_W-1:0] mask;
    logic [WORD_W-1:0] diff;
    logic [CNT_W-1:0]  errs;

    // Used bytes are the top ones; slide them down to line up with the newest bits.
    assign len_bits = CNT_W'((int'(size_sel) + 1) * BYTE_W);
    assign ref_word = word >> ((NUM_BYTES - 1 - int'(size_sel)) * BYTE_W);

    generate
        for (genvar g = 0; g < WORD_W; g++) begin : g_mask
            assign mask[g] = (CNT_W'(g) < len_bits);
        end
    endgenerate

    assign diff = (cand ^ ref_word) & mask;

    always_comb begin
        errs = '0;
        for (int i = 0; i < WORD_W; i++) begin
            errs = errs + CNT_W'(diff[i]);
        end
    end

    assign hit = (fill_cand >= len_bits) && (errs <= CNT_W'(tol_sel));
endmodule

// File: rtl/sd_ctrl.sv
module sd_ctrl
    import sdet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hunt_en,
    input  logic restart,
    input  logic bit_en,
    input  logic hit,
    output logic take,
    output logic clear,
    output logic found
);
    hunt_state_t state_q, state_d;
    logic        hunting;

    assign hunting = (state_q == ST_HUNT) && hunt_en;
    assign take    = hunting && !restart && bit_en;
    assign clear   = !hunting || restart;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (hunt_en) state_d = ST_HUNT;
            ST_HUNT: begin
                if (!hunt_en)          state_d = ST_IDLE;
                else if (restart)      state_d = ST_HUNT;
                else if (bit_en && hit) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!hunt_en)     state_d = ST_IDLE;
                else if (restart) state_d = ST_HUNT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) found <= 1'b0;
        else        found <= take && hit;
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        found |=> !found); // R5

    AST_HOLD_ON_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (state_q == ST_HOLD)); // R7

    AST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !restart) |=> !found); // R7

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !hunt_en |=> (state_q == ST_IDLE && !found)); // R8

    AST_FOUND_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> $past(bit_en)); // R9
endmodule

// File: rtl/sync_hunter.sv
module sync_hunter #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 4,
    parameter int SIZE_W    = 2,
    parameter int TOL_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hunt_en,
    input  logic                        restart,
    input  logic                        bit_en,
    input  logic                        bit_in,
    input  logic [SIZE_W-1:0]           size_sel,
    input  logic [TOL_W-1:0]            tol_sel,
    input  logic [BYTE_W*NUM_BYTES-1:0] word_bytes,
    output logic                        found
);
    localparam int WORD_W = BYTE_W * NUM_BYTES;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    logic              take;
    logic              clear;
    logic              hit;
    logic [WORD_W-1:0] cand;
    logic [CNT_W-1:0]  fill_cand;

    sd_history #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_history (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .take      (take),
        .bit_in    (bit_in),
        .cand      (cand),
        .fill_cand (fill_cand)
    );

    sd_compare #(
        .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES),
        .SIZE_W(SIZE_W), .TOL_W(TOL_W), .CNT_W(CNT_W)
    ) u_compare (
        .cand      (cand),
        .fill_cand (fill_cand),
        .word      (word_bytes),
        .size_sel  (size_sel),
        .tol_sel   (tol_sel),
        .hit       (hit)
    );

    sd_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hunt_en (hunt_en),
        .restart (restart),
        .bit_en  (bit_en),
        .hit     (hit),
        .take    (take),
        .clear   (clear),
        .found   (found)
    );
endmodule

// File: tb/sync_hunter_bench.sv
module sync_hunter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hunt_en = 1'b0;
    logic        restart = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic [1:0]  size_sel = 2'b11;
    logic [1:0]  tol_sel = 2'b00;
    logic [31:0] word_bytes = '0;
    logic        found;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    sync_hunter u_sync_hunter (
        .clk(clk), .rst_n(rst_n), .hunt_en(hunt_en), .restart(restart),
        .bit_en(bit_en), .bit_in(bit_in), .size_sel(size_sel),
        .tol_sel(tol_sel), .word_bytes(word_bytes), .found(found)
    );

    // Monitor: one expected value per driven cycle, compared after the edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            if (sb.size() > 0) begin
                e = sb.pop_front();
                @(negedge clk);
                n_checks++;
                if (found !== e.exp) begin
                    n_errors++;
                    $display("FAIL %s: found=%b expected=%b at %0t", e.tag, found, e.exp, $time);
                end
            end
        end
    end

    task automatic step(input logic en, input logic b, input logic exp, input string tag);
        bit_en = en;
        bit_in = b;
        sb.push_back('{exp: exp, tag: tag});
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n, input logic fire, input string tag);
        for (int i = n - 1; i >= 0; i--) begin
            step(1'b1, v[i], (i == 0) ? fire : 1'b0, tag);
        end
    endtask

    task automatic rearm(input string tag);
        restart = 1'b1;
        step(1'b1, 1'b1, 1'b0, tag);
        restart = 1'b0;
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (found !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: found=%b expected=0 during reset", found);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (found !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: found=%b expected=0 after reset", found);
        end

        // R1: hunting disabled, matching stream gives nothing
        word_bytes = 32'hC3A5_0F96;
        size_sel = 2'b11;
        tol_sel = 2'b00;
        send(32'hC3A5_0F96, 32, 1'b0, "R1");

        // arm, then full 32-bit match
        hunt_en = 1'b1;
        step(1'b0, 1'b0, 1'b0, "R8");
        send(32'hC3A5_0F96, 32, 1'b1, "R2");
        step(1'b0, 1'b0, 1'b0, "R5");
        send(32'hC3A5_0F96, 32, 1'b0, "R7");
        rearm("R7");
        send(32'hC3A5_0F96, 32, 1'b1, "R7");

        // 24-bit window, fourth byte ignored
        size_sel = 2'b10;
        word_bytes = 32'hC3A5_0F55;
        rearm("R2");
        send(32'h00C3_A50F, 24, 1'b1, "R2");

        // 16-bit window, bytes 3 and 4 ignored
        size_sel = 2'b01;
        word_bytes = 32'h5A3C_FFFF;
        rearm("R2");
        send(32'h0000_5A3C, 16, 1'b1, "R2");

        // R3: bit order, reversed byte does not match
        size_sel = 2'b00;
        word_bytes = 32'h80FF_FFFF;
        rearm("R3");
        send(32'h01, 8, 1'b0, "R3");
        send(32'h80, 8, 1'b1, "R3");

        // R6: window must fill before a match counts
        word_bytes = 32'h00FF_FFFF;
        tol_sel = 2'b11;
        rearm("R6");
        send(32'h00, 8, 1'b1, "R6");

        // R4: tolerance codes
        word_bytes = 32'hF0FF_FFFF;
        tol_sel = 2'b01;
        rearm("R4");
        send(32'hF1, 8, 1'b1, "R4");
        rearm("R4");
        send(32'hF3, 8, 1'b0, "R4");
        tol_sel = 2'b10;
        rearm("R4");
        send(32'hF3, 8, 1'b1, "R4");
        tol_sel = 2'b11;
        rearm("R4");
        send(32'hFF, 8, 1'b0, "R4");
        rearm("R4");
        send(32'hF7, 8, 1'b1, "R4");
        tol_sel = 2'b00;
        rearm("R4");
        send(32'hF1, 8, 1'b0, "R4");

        // R9: gaps with bit_in high are not taken
        word_bytes = 32'hA6FF_FFFF;
        rearm("R9");
        for (int i = 7; i >= 0; i--) begin
            step(1'b1, (8'hA6 >> i) & 1'b1, (i == 0), "R9");
            if (i > 0) step(1'b0, 1'b1, 1'b0, "R9");
        end

        // R8: disabling mid-word empties the window
        rearm("R8");
        send(32'hA, 4, 1'b0, "R8");
        hunt_en = 1'b0;
        step(1'b1, 1'b0, 1'b0, "R8");
        hunt_en = 1'b1;
        step(1'b0, 1'b0, 1'b0, "R8");
        send(32'h6, 4, 1'b0, "R8");
        send(32'hA6, 8, 1'b1, "R8");
        // leave hold by disabling, re-arm without restart
        hunt_en = 1'b0;
        step(1'b0, 1'b0, 1'b0, "R8");
        hunt_en = 1'b1;
        step(1'b0, 1'b0, 1'b0, "R8");
        send(32'hA6, 8, 1'b1, "R8");

        wait (sb.size() == 0);
        done = 1'b1;
        finish_run();
    end
endmodule